// File: doc/BRIEF.md
# Bit Slicer with Freezable Average Reference

This block turns filtered, decimated frequency-detector samples into hard data bits. Each incoming sample is compared against a reference. The reference is a running average of earlier samples, so it tracks the DC offset that the frequency error of the link leaves in the detector output. The average settles correctly only on a DC-balanced preamble, such as alternating ones and zeros.

Once the preamble has passed, the reference should stop moving so that long runs of equal bits do not drag it. The block freezes the average in one of two ways. In manual mode the host raises a lock request. In automatic mode a timer counts bit strobes from the moment receive becomes active and freezes the average when a settling count is reached. A frozen reference survives power-down and transmit periods. Only a modem reset or the main reset releases it.

The average is a first-order IIR filter with fractional bits. Its shift grows with the settling code, so a longer settling window also gives a slower, smoother filter.

Top module: `bit_slicer`

## Requirements
- R1: One cycle after a valid sample in active receive (rxEn=1, pwrDown=0), sliceBit is 1 when the sample, scaled by 2^F, is strictly greater than the average held before that sample; otherwise it is 0. F = BASE_SHIFT+3.
- R2: On each valid sample in active receive while not frozen, the average (fixed point, F fractional bits, zero after reset) becomes avg + floor((sample·2^F − avg) / 2^(BASE_SHIFT+settleCode)).
- R3: With autoLock=0, a 0→1 transition of lockReq freezes the average, and avgFrozen is 1 on the next cycle.
- R4: With autoLock=1, lockReq has no effect on the freeze state.
- R5: With autoLock=1, the timer restarts at every entry into active receive. The average freezes after exactly 16·2^settleCode bit strobes (codes 0,1,2,3 give 16, 32, 64, 128). avgFrozen rises in the cycle after the last strobe.
- R6: Leaving active receive before the timer expires stops the timer. The next entry restarts the count from zero.
- R7: Once frozen, the average and avgFrozen stay unchanged through pwrDown and rxEn low. On return to receive, slicing uses the frozen average.
- R8: modemRst (synchronous) and rstN (asynchronous, active low) clear the average, sliceBit and avgFrozen.
- R9: With autoLock=0 and lockReq held at 0, the average never freezes, however many bits pass.
- R10: avgFrozen is 0 after reset and shows whether the average is currently frozen.
- R11: Outside active receive, valid samples are ignored and sliceBit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low main reset |
| modemRst | input | 1 | Synchronous modem reset, clears the average and the lock state |
| pwrDown | input | 1 | Power-down; suspends slicing and averaging |
| rxEn | input | 1 | Receive enable; 0 means transmit or idle |
| sampleValid | input | 1 | Strobe for one decimated data-filter sample |
| sample | input | SAMPLE_W | Signed data-filter sample |
| bitStrobe | input | 1 | One pulse per received bit period |
| autoLock | input | 1 | 1 selects automatic (timer) lock; 0 selects manual lock |
| lockReq | input | 1 | Host lock request, used on its rising edge in manual mode |
| settleCode | input | 2 | Settling code: timer length and filter shift |
| sliceBit | output | 1 | Sliced data bit |
| avgFrozen | output | 1 | 1 while the average is frozen |

## Verification
On every cycle the assertions check the following:
- the frozen state stays set until a modem reset (R7);
- a modem reset clears it (R8);
- a manual rising edge of lockReq freezes the average (R3);
- in manual mode nothing but that edge can freeze it (R9);
- sliceBit holds whenever no sample arrives in active receive (R11).

Only the bench scenarios can show the remaining behaviour:
- the exact filter arithmetic and bit decisions (R1, R2), checked against a model computed in the bench;
- the exact strobe count at which each settling code freezes (R5), and the restart after leaving receive early (R6);
- that lockReq is ignored in automatic mode (R4);
- that the reference survives power-down and transmit and is used again on return (R7).

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  // Strobes from the lock control to the averaging datapath.
  typedef struct packed {
    logic avgUpd;   // fold this sample into the average
    logic sliceEn;  // make a bit decision on this sample
    logic clr;      // clear the average and the output bit
  } slice_ctl_t;
endpackage

// File: rtl/slicer_ctrl.sv
module slicer_ctrl
  import slicer_pkg::*;
#(
  parameter int BASE_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modemRst,
  input  logic       pwrDown,
  input  logic       rxEn,
  input  logic       sampleValid,
  input  logic       bitStrobe,
  input  logic       autoLock,
  input  logic       lockReq,
  input  logic [1:0] settleCode,
  output slice_ctl_t ctl,
  output logic       frozen
);
  localparam int MAX_BITS = BASE_BITS * 8;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic             rxActive, rxActQ, rxEntry;
  logic             timerRun, lockReqQ, manualRise;
  logic [CNT_W-1:0] bitCnt, bitLimit;

  assign rxActive   = rxEn & ~pwrDown;
  assign rxEntry    = rxActive & ~rxActQ;
  assign manualRise = ~autoLock & lockReq & ~lockReqQ;
  assign bitLimit   = CNT_W'(BASE_BITS) << settleCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockReqQ <= 1'b1;
    else       lockReqQ <= lockReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frozen   <= 1'b0;
      timerRun <= 1'b0;
      bitCnt   <= '0;
      rxActQ   <= 1'b0;
    end else if (modemRst) begin
      frozen   <= 1'b0;
      timerRun <= 1'b0;
      bitCnt   <= '0;
      rxActQ   <= 1'b0;
    end else begin
      rxActQ <= rxActive;
      if (rxEntry) begin
        timerRun <= 1'b1;
        bitCnt   <= '0;
      end else if (!rxActive) begin
        timerRun <= 1'b0;
      end else if (timerRun && autoLock && !frozen && bitStrobe) begin
        if (bitCnt == bitLimit - 1'b1) begin
          frozen   <= 1'b1;
          timerRun <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (manualRise) frozen <= 1'b1;
    end
  end

  always_comb begin
    ctl.sliceEn = sampleValid & rxActive;
    ctl.avgUpd  = sampleValid & rxActive & ~frozen;
    ctl.clr     = modemRst;
  end
endmodule

// File: rtl/slicer_dpath.sv
module slicer_dpath
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int BASE_SHIFT = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slice_ctl_t                 ctl,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [1:0]                 settleCode,
  output logic                       sliceBit
);
  localparam int FRAC_W = BASE_SHIFT + 3;
  localparam int ACC_W  = SAMPLE_W + FRAC_W + 1;
  localparam int SH_W   = $clog2(FRAC_W + 1);

  logic signed [ACC_W-1:0] acc, sampleExt;
  logic signed [ACC_W:0]   diff, step;
  logic [SH_W-1:0]         shiftAmt;

  assign sampleExt = $signed({sample[SAMPLE_W-1], sample, {FRAC_W{1'b0}}});
  assign shiftAmt  = SH_W'(BASE_SHIFT) + SH_W'(settleCode);
  assign diff      = $signed({sampleExt[ACC_W-1], sampleExt}) - $signed({acc[ACC_W-1], acc});
  assign step      = diff >>> shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      sliceBit <= 1'b0;
    end else if (ctl.clr) begin
      acc      <= '0;
      sliceBit <= 1'b0;
    end else begin
      if (ctl.sliceEn) sliceBit <= (sampleExt > acc);
      if (ctl.avgUpd)  acc      <= acc + step[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/bit_slicer.sv
module bit_slicer
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int BASE_SHIFT = 2,
  parameter int BASE_BITS  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modemRst,
  input  logic                       pwrDown,
  input  logic                       rxEn,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       bitStrobe,
  input  logic                       autoLock,
  input  logic                       lockReq,
  input  logic [1:0]                 settleCode,
  output logic                       sliceBit,
  output logic                       avgFrozen
);
  slice_ctl_t ctl;

  slicer_ctrl #(.BASE_BITS(BASE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .modemRst(modemRst), .pwrDown(pwrDown),
    .rxEn(rxEn), .sampleValid(sampleValid), .bitStrobe(bitStrobe),
    .autoLock(autoLock), .lockReq(lockReq), .settleCode(settleCode),
    .ctl(ctl), .frozen(avgFrozen)
  );

  slicer_dpath #(.SAMPLE_W(SAMPLE_W), .BASE_SHIFT(BASE_SHIFT)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sample(sample),
    .settleCode(settleCode), .sliceBit(sliceBit)
  );
endmodule

// File: rtl/bit_slicer_chk.sv
module bit_slicer_chk (
  input logic clk,
  input logic rstN,
  input logic modemRst,
  input logic pwrDown,
  input logic rxEn,
  input logic sampleValid,
  input logic autoLock,
  input logic lockReq,
  input logic sliceBit,
  input logic avgFrozen
);
  p_frozen_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    avgFrozen && !modemRst |=> avgFrozen);

  p_modem_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    modemRst |=> !avgFrozen && !sliceBit);

  p_manual_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    !autoLock && $rose(lockReq) && !modemRst |=> avgFrozen);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !avgFrozen && !autoLock && !$rose(lockReq) |=> !avgFrozen);

  p_slice_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && rxEn && !pwrDown) && !modemRst |=> $stable(sliceBit));
endmodule

bind bit_slicer bit_slicer_chk u_chk (
  .clk(clk), .rstN(rstN), .modemRst(modemRst), .pwrDown(pwrDown),
  .rxEn(rxEn), .sampleValid(sampleValid), .autoLock(autoLock),
  .lockReq(lockReq), .sliceBit(sliceBit), .avgFrozen(avgFrozen)
);

// File: tb/bit_slicer_bench.sv
module bit_slicer_bench;
  localparam int F  = 5;  // BASE_SHIFT + 3
  localparam int BS = 2;  // BASE_SHIFT

  logic clk = 1'b0;
  logic rstN = 1'b0, modemRst = 1'b0, pwrDown = 1'b0, rxEn = 1'b0;
  logic sampleValid = 1'b0, bitStrobe = 1'b0, autoLock = 1'b0, lockReq = 1'b0;
  logic signed [7:0] sample = '0;
  logic [1:0] settleCode = 2'd0;
  logic sliceBit, avgFrozen;

  int total = 0, bad = 0;
  int mAvg = 0;
  bit mFrozen = 0, mBit = 0, done = 0;

  always #10 clk = ~clk;

  bit_slicer u_bit_slicer (
    .clk(clk), .rstN(rstN), .modemRst(modemRst), .pwrDown(pwrDown), .rxEn(rxEn),
    .sampleValid(sampleValid), .sample(sample), .bitStrobe(bitStrobe),
    .autoLock(autoLock), .lockReq(lockReq), .settleCode(settleCode),
    .sliceBit(sliceBit), .avgFrozen(avgFrozen)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendSample(input int s, input string req);
    @(negedge clk);
    sample = 8'(s);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    if (rxEn && !pwrDown) begin
      mBit = ((s * (1 << F)) > mAvg);
      if (!mFrozen) mAvg = mAvg + ((s * (1 << F) - mAvg) >>> (BS + int'(settleCode)));
    end
    chk(req, int'(sliceBit), int'(mBit));
  endtask

  task automatic strobe();
    @(negedge clk);
    bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
  endtask

  task automatic doModemReset();
    @(negedge clk);
    modemRst = 1'b1;
    @(negedge clk);
    modemRst = 1'b0;
    mAvg = 0;
    mFrozen = 0;
    mBit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset frozen", int'(avgFrozen), 0);
    chk("R8 reset bit", int'(sliceBit), 0);
    rstN = 1'b1;

    // Automatic lock: every settling code (R1 R2 R4 R5 R7 R11)
    for (int code = 0; code < 4; code++) begin
      @(negedge clk);
      rxEn = 1'b0;
      autoLock = 1'b1;
      settleCode = 2'(code);
      doModemReset();
      @(negedge clk);
      rxEn = 1'b1;
      for (int b = 0; b < (16 << code); b++) begin
        sendSample(((b % 2) != 0) ? 40 + 5 * code : -30 + 3 * code, "R1 R2 preamble");
        sendSample(((b * 53 + 17 * code) % 200) - 100, "R1 R2 mixed");
        if (b == 3) begin
          @(negedge clk);
          lockReq = 1'b1;
        end
        if (b == 5) begin
          @(negedge clk);
          lockReq = 1'b0;
          chk("R4 lockReq ignored", int'(avgFrozen), 0);
        end
        if (b == (16 << code) - 1) chk("R5 not yet frozen", int'(avgFrozen), 0);
        strobe();
      end
      chk("R5 frozen at limit", int'(avgFrozen), 1);
      mFrozen = 1;
      for (int i = 0; i < 6; i++) sendSample((i * 41) % 120 - 60, "R1 frozen slice");
      @(negedge clk);
      pwrDown = 1'b1;
      for (int i = 0; i < 3; i++) sendSample(i * 30 - 50, "R11 powerdown ignore");
      @(negedge clk);
      pwrDown = 1'b0;
      rxEn = 1'b0;
      for (int i = 0; i < 3; i++) sendSample(60 - i * 45, "R11 transmit ignore");
      chk("R7 frozen kept", int'(avgFrozen), 1);
      @(negedge clk);
      rxEn = 1'b1;
      for (int i = 0; i < 6; i++) sendSample(i * 23 - 70, "R7 slice on frozen avg");
    end

    // Modem reset clears (R8)
    doModemReset();
    chk("R8 frozen cleared", int'(avgFrozen), 0);
    chk("R8 bit cleared", int'(sliceBit), 0);
    sendSample(0, "R8 zero average");
    sendSample(1, "R8 zero average");

    // Leaving receive stops timer, re-entry restarts (R6)
    @(negedge clk);
    settleCode = 2'd0;
    doModemReset();
    for (int b = 0; b < 10; b++) strobe();
    @(negedge clk);
    rxEn = 1'b0;
    for (int b = 0; b < 10; b++) strobe();
    chk("R6 timer stopped", int'(avgFrozen), 0);
    @(negedge clk);
    rxEn = 1'b1;
    for (int b = 0; b < 15; b++) strobe();
    chk("R6 restart count", int'(avgFrozen), 0);
    strobe();
    chk("R6 frozen after restart", int'(avgFrozen), 1);

    // Manual mode: no freeze without request (R9), then rising edge (R3)
    @(negedge clk);
    autoLock = 1'b0;
    settleCode = 2'd1;
    doModemReset();
    for (int b = 0; b < 200; b++) begin
      if ((b % 20) == 0) sendSample((b * 7) % 90 - 45, "R2 manual running");
      strobe();
    end
    chk("R9 never frozen", int'(avgFrozen), 0);
    @(negedge clk);
    lockReq = 1'b1;
    @(negedge clk);
    chk("R3 manual freeze", int'(avgFrozen), 1);
    mFrozen = 1;
    for (int i = 0; i < 5; i++) sendSample(i * 31 - 62, "R3 frozen slice");
    lockReq = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule